// File: doc/BRIEF.md
# Maskable Interrupt Entry and Return Sequencer

This block owns the maskable-interrupt path of a small 8-bit CPU core. It holds the stack pointer and the interrupt-disable flag. It also runs the bus cycles that move control into an interrupt handler and back out of it. The core's decoder raises `step` at every instruction boundary and uses `kind` to say what the next instruction needs from this block.

At a boundary the sequencer samples the active-low request `irq_n` against the disable flag. If the request wins, the next instruction is discarded and a seven-cycle entry sequence runs:

1. Two dummy reads at the return address.
2. Three pushes to the stack page: PC high byte, PC low byte, then status.
3. Two vector reads that produce the new program counter.

If the request does not win, the sequencer carries out the named instruction: set the flag, clear the flag, do nothing, or return from interrupt. The return pulls status and PC back from the stack.

The request is a level and is not latched. A source that has not been acknowledged therefore takes the processor back into its handler at the first boundary after the flag is cleared again.

States of the machine:

- `ST_IDLE` waits for a boundary.
- Entry runs through `ST_E_DUM0` → `ST_E_DUM1` → `ST_E_PCH` → `ST_E_PCL` → `ST_E_PSR` → `ST_E_VLO` → `ST_E_VHI` and then back to `ST_IDLE`. This path is taken from `ST_IDLE` when `step` is high, `irq_n` is low and the flag is clear.
- Return runs through `ST_R_DUM0` → `ST_R_DUM1` → `ST_R_PSR` → `ST_R_PCL` → `ST_R_PCH` and then back to `ST_IDLE`. This path is taken from `ST_IDLE` on a `step` whose `kind` is return and which is not pre-empted by a request.
- Set-flag, clear-flag and no-op steps stay in `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the sequencer is idle. `busy`, `bus_rd`, `bus_wr`, `pc_load` and `psr_load` are 0, `mask` is 1 and `sp` is 0xFF.
- R2: A `step` accepted while `irq_n` is 0 and `mask` is 0 starts entry, and the supplied `kind` is discarded. `busy` is 1 for exactly the seven cycles after the step cycle.
- R3: Entry writes the PC high byte to 0x0100+sp, the PC low byte to 0x0100+sp-1 and the status byte to 0x0100+sp-2. Every write lands in page 0x01, and sp drops by one after each write.
- R4: The pushed status byte is `psr_in` with bit 2 (the disable flag) carrying the flag value from before entry. `mask` becomes 1 in the cycle after the status push and is 1 when entry completes.
- R5: Entry first reads twice at the captured `pc_in`, then reads 0xFFFE and then 0xFFFF. In the cycle after the last read, `pc_load` pulses for one cycle with `pc_out` = {byte at 0xFFFF, byte at 0xFFFE}.
- R6: While `mask` is 1, a low `irq_n` is ignored and the step's own `kind` is carried out.
- R7: The `kind` codes are 0 no-op, 1 set flag, 2 clear flag and 3 return. Set and clear change `mask` in the cycle after the step. A no-op leaves it unchanged.
- R8: Return takes five cycles:
  - a dummy read at `pc_in`;
  - a dummy read at 0x0100+sp;
  - pulls from 0x0100+sp+1, +2 and +3, with sp rising by one per pull.

  `mask` takes bit 2 of the first pulled byte. In the next cycle `pc_load` and `psr_load` pulse, with `psr_out` = first byte and `pc_out` = {third, second}.
- R9: If `irq_n` is still 0 after a return restored a clear flag, the next step enters again.
- R10: A `step` raised while `busy` is 1 is ignored.
- R11: `bus_rd` and `bus_wr` are never 1 together, and `busy` is 1 exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_n | input | 1 | Active-low interrupt request level |
| step | input | 1 | Instruction boundary strobe |
| kind | input | 2 | Next instruction class: 0 none, 1 set flag, 2 clear flag, 3 return |
| pc_in | input | 16 | Return address captured at the boundary |
| psr_in | input | 8 | Status byte from the core, captured at the boundary |
| bus_rdata | input | 8 | Read data, valid in the cycle of the access |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| busy | output | 1 | Sequence in progress |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | One-cycle strobe: load `pc_out` |
| psr_out | output | 8 | Restored status byte |
| psr_load | output | 1 | One-cycle strobe: load `psr_out` |
| mask | output | 1 | Interrupt-disable flag |
| sp | output | 8 | Stack pointer |

## Verification
The hardest situation to reach is a re-entry caused purely by the request still being low: a return restores a clear flag, and the very next boundary must enter again without any new edge on `irq_n`. The bench builds this from a directed chain (clear, enter, return with the request still asserted, step again). It then walks the random phase with a request that is low most of the time, so return, clear and entry steps keep interleaving with the stack wrapping through its page. Steps are also injected mid-sequence to show they are ignored.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_E_DUM0,
        ST_E_DUM1,
        ST_E_PCH,
        ST_E_PCL,
        ST_E_PSR,
        ST_E_VLO,
        ST_E_VHI,
        ST_R_DUM0,
        ST_R_DUM1,
        ST_R_PSR,
        ST_R_PCL,
        ST_R_PCH
    } seq_state_t;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_SETM = 2'd1,
        K_CLRM = 2'd2,
        K_RETI = 2'd3
    } step_kind_t;

    typedef enum logic [2:0] {
        A_PC,
        A_SP,
        A_SP1,
        A_VLO,
        A_VHI
    } addr_sel_t;

    typedef enum logic [1:0] {
        W_PCH,
        W_PCL,
        W_PSR
    } wdat_sel_t;

    typedef struct packed {
        logic      rd;
        logic      wr;
        addr_sel_t asel;
        wdat_sel_t wsel;
        logic      sp_dec;
        logic      sp_inc;
        logic      m_set;
        logic      m_clr;
        logic      m_load;
        logic      lo_cap;
        logic      pc_done;
        logic      psr_done;
    } seq_ctl_t;

endpackage

// File: rtl/irq_stack_ptr.sv
module irq_stack_ptr #(
    parameter int          DW      = 8,
    parameter logic [7:0]  SP_INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec,
    input  logic          inc,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_next_up
);

    localparam logic [DW-1:0] ONE = DW'(1);

    assign sp_next_up = sp + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= DW'(SP_INIT);
        end else if (dec) begin
            sp <= sp - ONE;
        end else if (inc) begin
            sp <= sp_next_up;
        end
    end

    AST_SP_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec && inc));  // R11

endmodule

// File: rtl/irq_mask_flag.sv
module irq_mask_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic load,
    input  logic load_val,
    output logic mask
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= 1'b1;
        end else if (load) begin
            mask <= load_val;
        end else if (set) begin
            mask <= 1'b1;
        end else if (clr) begin
            mask <= 1'b0;
        end
    end

    AST_MASK_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({set, clr, load}) <= 1);  // R7

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic [1:0] kind,
    input  logic       irq_n,
    input  logic       mask,
    output seq_state_t state,
    output logic       accept,
    output seq_ctl_t   ctl
);

    seq_state_t nxt;
    step_kind_t k;
    logic       take;

    assign k      = step_kind_t'(kind);
    assign accept = step && (state == ST_IDLE);
    assign take   = accept && !irq_n && !mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (take) begin
                    nxt = ST_E_DUM0;
                end else if (accept && k == K_RETI) begin
                    nxt = ST_R_DUM0;
                end
            end
            ST_E_DUM0: nxt = ST_E_DUM1;
            ST_E_DUM1: nxt = ST_E_PCH;
            ST_E_PCH:  nxt = ST_E_PCL;
            ST_E_PCL:  nxt = ST_E_PSR;
            ST_E_PSR:  nxt = ST_E_VLO;
            ST_E_VLO:  nxt = ST_E_VHI;
            ST_E_VHI:  nxt = ST_IDLE;
            ST_R_DUM0: nxt = ST_R_DUM1;
            ST_R_DUM1: nxt = ST_R_PSR;
            ST_R_PSR:  nxt = ST_R_PCL;
            ST_R_PCL:  nxt = ST_R_PCH;
            ST_R_PCH:  nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl      = '0;
        ctl.asel = A_PC;
        ctl.wsel = W_PCH;
        unique case (state)
            ST_IDLE: begin
                ctl.m_set = accept && !take && (k == K_SETM);
                ctl.m_clr = accept && !take && (k == K_CLRM);
            end
            ST_E_DUM0, ST_E_DUM1, ST_R_DUM0: begin
                ctl.rd   = 1'b1;
                ctl.asel = A_PC;
            end
            ST_E_PCH: begin
                ctl.wr     = 1'b1;
                ctl.asel   = A_SP;
                ctl.wsel   = W_PCH;
                ctl.sp_dec = 1'b1;
            end
            ST_E_PCL: begin
                ctl.wr     = 1'b1;
                ctl.asel   = A_SP;
                ctl.wsel   = W_PCL;
                ctl.sp_dec = 1'b1;
            end
            ST_E_PSR: begin
                ctl.wr     = 1'b1;
                ctl.asel   = A_SP;
                ctl.wsel   = W_PSR;
                ctl.sp_dec = 1'b1;
                ctl.m_set  = 1'b1;
            end
            ST_E_VLO: begin
                ctl.rd     = 1'b1;
                ctl.asel   = A_VLO;
                ctl.lo_cap = 1'b1;
            end
            ST_E_VHI: begin
                ctl.rd      = 1'b1;
                ctl.asel    = A_VHI;
                ctl.pc_done = 1'b1;
            end
            ST_R_DUM1: begin
                ctl.rd   = 1'b1;
                ctl.asel = A_SP;
            end
            ST_R_PSR: begin
                ctl.rd     = 1'b1;
                ctl.asel   = A_SP1;
                ctl.sp_inc = 1'b1;
                ctl.m_load = 1'b1;
            end
            ST_R_PCL: begin
                ctl.rd     = 1'b1;
                ctl.asel   = A_SP1;
                ctl.sp_inc = 1'b1;
                ctl.lo_cap = 1'b1;
            end
            ST_R_PCH: begin
                ctl.rd       = 1'b1;
                ctl.asel     = A_SP1;
                ctl.sp_inc   = 1'b1;
                ctl.pc_done  = 1'b1;
                ctl.psr_done = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    AST_MASKED_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mask) |=> (state != ST_E_DUM0));  // R6
    AST_REQ_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !irq_n && !mask) |=> (state == ST_E_DUM0));  // R2

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          MASK_BIT = 2,
    parameter logic [7:0]  SP_INIT  = 8'hFF,
    parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        irq_n,
    input  logic        step,
    input  logic [1:0]  kind,
    input  logic [15:0] pc_in,
    input  logic [7:0]  psr_in,
    input  logic [7:0]  bus_rdata,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic        busy,
    output logic [15:0] pc_out,
    output logic        pc_load,
    output logic [7:0]  psr_out,
    output logic        psr_load,
    output logic        mask,
    output logic [7:0]  sp
);

    localparam int             AW       = 2 * DW;
    localparam logic [DW-1:0]  STK_PAGE = DW'(1);
    localparam logic [AW-1:0]  VEC_HI   = VEC_ADDR + AW'(1);

    seq_state_t      state;
    seq_ctl_t        ctl;
    logic            accept;
    logic [DW-1:0]   sp_up;
    logic [AW-1:0]   ret_pc;
    logic [DW-1:0]   ret_psr;
    logic [DW-1:0]   psr_push;
    logic [DW-1:0]   lo_q;
    logic [DW-1:0]   pulled_psr;

    irq_seq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .kind   (kind),
        .irq_n  (irq_n),
        .mask   (mask),
        .state  (state),
        .accept (accept),
        .ctl    (ctl)
    );

    irq_stack_ptr #(.DW(DW), .SP_INIT(SP_INIT)) u_sp (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (ctl.sp_dec),
        .inc        (ctl.sp_inc),
        .sp         (sp),
        .sp_next_up (sp_up)
    );

    irq_mask_flag u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (ctl.m_set),
        .clr      (ctl.m_clr),
        .load     (ctl.m_load),
        .load_val (bus_rdata[MASK_BIT]),
        .mask     (mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_pc  <= '0;
            ret_psr <= '0;
        end else if (accept) begin
            ret_pc  <= pc_in;
            ret_psr <= psr_in;
        end
    end

    always_comb begin
        psr_push           = ret_psr;
        psr_push[MASK_BIT] = mask;
    end

    always_comb begin
        unique case (ctl.asel)
            A_PC:    bus_addr = ret_pc;
            A_SP:    bus_addr = {STK_PAGE, sp};
            A_SP1:   bus_addr = {STK_PAGE, sp_up};
            A_VLO:   bus_addr = VEC_ADDR;
            A_VHI:   bus_addr = VEC_HI;
            default: bus_addr = ret_pc;
        endcase
    end

    always_comb begin
        unique case (ctl.wsel)
            W_PCH:   bus_wdata = ret_pc[AW-1:DW];
            W_PCL:   bus_wdata = ret_pc[DW-1:0];
            W_PSR:   bus_wdata = psr_push;
            default: bus_wdata = '0;
        endcase
    end

    assign bus_rd = ctl.rd;
    assign bus_wr = ctl.wr;
    assign busy   = (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q       <= '0;
            pulled_psr <= '0;
            pc_out     <= '0;
            psr_out    <= '0;
            pc_load    <= 1'b0;
            psr_load   <= 1'b0;
        end else begin
            pc_load  <= ctl.pc_done;
            psr_load <= ctl.psr_done;
            if (ctl.lo_cap) begin
                lo_q <= bus_rdata;
            end
            if (ctl.m_load) begin
                pulled_psr <= bus_rdata;
            end
            if (ctl.pc_done) begin
                pc_out <= {bus_rdata, lo_q};
            end
            if (ctl.psr_done) begin
                psr_out <= pulled_psr;
            end
        end
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));  // R11
    AST_BUSY_MEANS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (bus_rd || bus_wr));  // R11
    AST_PUSH_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> (bus_addr[AW-1:DW] == STK_PAGE));  // R3
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (sp == $past(sp) - DW'(1)));  // R3
    AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !psr_load) |-> mask);  // R4
    AST_LOAD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        psr_load |-> pc_load);  // R8
    AST_BUSY_STEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step) |=> $stable(ret_pc));  // R10
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !busy && irq_n && kind == 2'd2) |=> !mask);  // R7

endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1;
    logic        step = 1'b0;
    logic [1:0]  kind = 2'd0;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  psr_in = 8'h0;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_rd, bus_wr, busy, pc_load, psr_load, mask;
    logic [15:0] pc_out;
    logic [7:0]  psr_out, sp;

    logic [7:0]  stk [256];
    logic [7:0]  vlo = 8'h34, vhi = 8'h12;
    int          n_chk = 0, n_fail = 0;
    logic        m_mask;
    logic [7:0]  m_sp;

    always #2 clk = ~clk;

    irq_entry_seq u0 (.*);

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        if (a[15:8] == 8'h01) return stk[a[7:0]];
        if (a == 16'hFFFE) return vlo;
        if (a == 16'hFFFF) return vhi;
        return a[7:0] ^ a[15:8];
    endfunction

    assign bus_rdata = mem_rd(bus_addr);

    always @(posedge clk) begin
        if (bus_wr && bus_addr[15:8] == 8'h01) stk[bus_addr[7:0]] <= bus_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bus(input string tag, input bit rd, input bit wr,
                           input logic [15:0] a, input logic [7:0] wd);
        chk({tag, " rd"}, bus_rd, rd);
        chk({tag, " wr"}, bus_wr, wr);
        chk({tag, " busy"}, busy, 1'b1);
        chk({tag, " addr"}, bus_addr, a);
        if (wr) chk({tag, " wdata"}, bus_wdata, wd);
    endtask

    task automatic run_step(input logic [1:0] k, input logic rq,
                            input logic [15:0] pcv, input logic [7:0] psv, input bit poke);
        logic [7:0] p, lo, hi;
        @(negedge clk);
        irq_n = rq; step = 1'b1; kind = k; pc_in = pcv; psr_in = psv;
        @(negedge clk);
        step = 1'b0; kind = 2'($urandom); pc_in = 16'($urandom);
        if (!rq && !m_mask) begin
            for (int i = 0; i < 7; i++) begin
                case (i)
                    0, 1: chk_bus("R5 dummy", 1, 0, pcv, 8'h0);
                    2: chk_bus("R3 push pch", 0, 1, {8'h01, m_sp}, pcv[15:8]);
                    3: chk_bus("R3 push pcl", 0, 1, {8'h01, 8'(m_sp - 1)}, pcv[7:0]);
                    4: begin
                        chk_bus("R4 push psr", 0, 1, {8'h01, 8'(m_sp - 2)}, psv & 8'hFB);
                        chk("R4 mask before", mask, 1'b0);
                    end
                    5: begin
                        chk_bus("R5 vec lo", 1, 0, 16'hFFFE, 8'h0);
                        chk("R4 mask set", mask, 1'b1);
                    end
                    default: chk_bus("R5 vec hi", 1, 0, 16'hFFFF, 8'h0);
                endcase
                if (poke && i == 2) step = 1'b1;
                if (i == 3) step = 1'b0;
                @(negedge clk);
            end
            m_sp = m_sp - 8'd3; m_mask = 1'b1;
            chk("R2 busy end", busy, 1'b0);
            chk("R5 pc_load", pc_load, 1'b1);
            chk("R5 pc_out", pc_out, {vhi, vlo});
            chk("R3 sp", sp, m_sp);
            chk("R4 mask", mask, 1'b1);
            chk("R10 no restart", bus_rd, 1'b0);
        end else if (k == 2'd3) begin
            p = stk[8'(m_sp + 1)]; lo = stk[8'(m_sp + 2)]; hi = stk[8'(m_sp + 3)];
            for (int i = 0; i < 5; i++) begin
                case (i)
                    0: chk_bus("R8 dummy pc", 1, 0, pcv, 8'h0);
                    1: chk_bus("R8 dummy stk", 1, 0, {8'h01, m_sp}, 8'h0);
                    default: chk_bus("R8 pull", 1, 0, {8'h01, 8'(m_sp + 8'(i - 1))}, 8'h0);
                endcase
                if (poke && i == 1) step = 1'b1;
                if (i == 2) step = 1'b0;
                @(negedge clk);
            end
            m_sp = m_sp + 8'd3; m_mask = p[2];
            chk("R8 busy end", busy, 1'b0);
            chk("R8 pc_load", pc_load, 1'b1);
            chk("R8 psr_load", psr_load, 1'b1);
            chk("R8 pc_out", pc_out, {hi, lo});
            chk("R8 psr_out", psr_out, p);
            chk("R8 mask", mask, m_mask);
            chk("R8 sp", sp, m_sp);
        end else begin
            if (k == 2'd1) m_mask = 1'b1;
            if (k == 2'd2) m_mask = 1'b0;
            chk(rq ? "R7 mask" : "R6 masked mask", mask, m_mask);
            chk("R6 no entry", busy, 1'b0);
            chk("R7 no access", bus_rd | bus_wr, 1'b0);
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) stk[i] = 8'(i * 37 + 5);
        m_mask = 1'b1; m_sp = 8'hFF;
        repeat (3) @(negedge clk);
        chk("R1 busy", busy, 1'b0);
        chk("R1 rd", bus_rd, 1'b0);
        chk("R1 wr", bus_wr, 1'b0);
        chk("R1 pc_load", pc_load, 1'b0);
        chk("R1 psr_load", psr_load, 1'b0);
        chk("R1 mask", mask, 1'b1);
        chk("R1 sp", sp, 8'hFF);
        rst_n = 1'b1;
        run_step(2'd0, 1'b0, 16'h8000, 8'h24, 0);   // R6: masked from reset
        run_step(2'd2, 1'b1, 16'h8001, 8'h20, 0);   // R7 clear
        run_step(2'd0, 1'b1, 16'h8002, 8'h20, 0);   // R7 no-op
        run_step(2'd1, 1'b0, 16'hA5C3, 8'hC3, 1);   // R2: request wins over set, busy poke R10
        run_step(2'd3, 1'b0, 16'hC000, 8'h00, 1);   // R8 return, request still low
        run_step(2'd0, 1'b0, 16'hA5C4, 8'h81, 0);   // R9 re-entry
        run_step(2'd1, 1'b0, 16'hC010, 8'h00, 0);   // R6 set inside handler
        run_step(2'd3, 1'b1, 16'hC011, 8'h00, 0);
        vlo = 8'h00; vhi = 8'hFF;
        run_step(2'd3, 1'b0, 16'hFFF0, 8'hFF, 0);   // return with mask 0 restored, then R9
        for (int it = 0; it < 400; it++) begin
            vlo = 8'($urandom); vhi = 8'($urandom);
            run_step(2'($urandom), ($urandom % 4) == 0, 16'($urandom), 8'($urandom),
                     ($urandom % 3) == 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule